// File: doc/BRIEF.md
# Top-K Nearest Distance Ranker

This block keeps a running list of the K closest matches found during a similarity search. A distance engine upstream produces one distance/identifier pair per clock. The ranker compares each new distance with every stored entry in the same cycle. A winning candidate is slotted into its ordered position, the entries behind it move one place down, and the former last entry is lost once the list is full. Candidates that do not beat the current last entry are dropped without any effect.

Software starts a search by pulsing the clear input. It then streams the candidate database through the block. When the stream is done, it reads the list back one rank at a time through a registered read port. Rank 0 is always the smallest distance.

A small controller tracks how full the list is, using three named states. EMPTY is the state after reset or clear. An accepted candidate in EMPTY leads to FILLING, or straight to FULL when K is 1. In FILLING, the acceptance that brings the count to K leads to FULL. FULL is left only by a clear. A clear sends every state back to EMPTY.

Top module: `rank_keeper`

## Requirements
- R1: After reset, or on the cycle after a clear, the fill count is 0 and every rank reads back with the hit flag low.
- R2: Ranks 0 through fill count minus 1 hold valid entries whose distances do not decrease with rank.
- R3: A candidate can be presented on every clock with no gaps, and each one is evaluated on the edge at which it is presented.
- R4: An accepted candidate takes the first rank whose stored distance is strictly greater than its own, or the first empty rank. Entries from that rank onward move down by one, and the entry at rank K-1 is discarded.
- R5: When the list is full, a candidate whose distance is greater than or equal to the rank K-1 distance leaves every entry unchanged.
- R6: When two candidates have equal distances, the one that arrived first holds the lower rank.
- R7: Each accepted candidate raises the fill count by one, up to K (15 by default). Once the count is K it stays at K until a clear.
- R8: When clear and a candidate valid are both high in the same cycle, the clear wins and the candidate is discarded.
- R9: The read port registers its result. A rank index applied before a clock edge returns that rank's distance, identifier and hit flag after the edge, taken from the list as it stood before that edge. An index of K or more returns hit low with zero distance and identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Start a new search: empties the list |
| cand_vld_i | input | 1 | Candidate present this cycle |
| cand_dist_i | input | DIST_W (32) | Candidate distance, unsigned |
| cand_id_i | input | ID_W (16) | Candidate vector identifier |
| rd_rank_i | input | clog2(K) (4) | Rank to read back |
| rd_hit_o | output | 1 | Read rank holds a valid entry |
| rd_dist_o | output | DIST_W (32) | Distance at the read rank |
| rd_id_o | output | ID_W (16) | Identifier at the read rank |
| fill_cnt_o | output | clog2(K+1) (4) | Number of valid entries |

## Verification
A candidate or clear takes effect on the next edge. The fill count shows it right after that edge. The read port adds one more register, so a rank read issued in the cycle after a candidate returns the updated list one edge later. The bench drives inputs and samples outputs on the falling edge. After the last candidate it waits one edge before it applies a rank index, and it checks the result one edge after that. Expected lists come from a behavioural insertion model that follows R4 and R6.

// File: rtl/rk_pkg.sv
package rk_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;
endpackage

// File: rtl/rk_compare.sv
module rk_compare #(
    parameter int K      = 15,
    parameter int DIST_W = 32
) (
    input  logic [K-1:0]             slot_vld,
    input  logic [K-1:0][DIST_W-1:0] slot_dist,
    input  logic [DIST_W-1:0]        cand_dist,
    output logic [K-1:0]             beats,
    output logic                     ins_any
);
    // A slot is beaten when it is empty or holds a strictly larger distance.
    // Strict compare keeps the earlier arrival ahead on ties (R6).
    for (genvar g = 0; g < K; g++) begin : g_cmp
        assign beats[g] = !slot_vld[g] || (cand_dist < slot_dist[g]);
    end

    assign ins_any = |beats;
endmodule

// File: rtl/rk_store.sv
module rk_store #(
    parameter int K      = 15,
    parameter int DIST_W = 32,
    parameter int ID_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     ins_en,
    input  logic [K-1:0]             beats,
    input  logic [DIST_W-1:0]        cand_dist,
    input  logic [ID_W-1:0]          cand_id,
    output logic [K-1:0]             slot_vld,
    output logic [K-1:0][DIST_W-1:0] slot_dist,
    output logic [K-1:0][ID_W-1:0]   slot_id
);
    logic [K-1:0]             nxt_vld;
    logic [K-1:0][DIST_W-1:0] nxt_dist;
    logic [K-1:0][ID_W-1:0]   nxt_id;

    // The beaten mask is a suffix: the first set bit takes the candidate,
    // the later set bits take their upper neighbour, the last entry falls off.
    always_comb begin
        nxt_vld  = slot_vld;
        nxt_dist = slot_dist;
        nxt_id   = slot_id;
        if (beats[0]) begin
            nxt_vld[0]  = 1'b1;
            nxt_dist[0] = cand_dist;
            nxt_id[0]   = cand_id;
        end
        for (int i = 1; i < K; i++) begin
            if (beats[i]) begin
                if (beats[i-1]) begin
                    nxt_vld[i]  = slot_vld[i-1];
                    nxt_dist[i] = slot_dist[i-1];
                    nxt_id[i]   = slot_id[i-1];
                end else begin
                    nxt_vld[i]  = 1'b1;
                    nxt_dist[i] = cand_dist;
                    nxt_id[i]   = cand_id;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld  <= '0;
            slot_dist <= '0;
            slot_id   <= '0;
        end else if (clr) begin
            slot_vld  <= '0;
        end else if (ins_en) begin
            slot_vld  <= nxt_vld;
            slot_dist <= nxt_dist;
            slot_id   <= nxt_id;
        end
    end

    for (genvar g = 0; g < K - 1; g++) begin : g_chk
        // R2: valid neighbours never descend in distance
        p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[g+1] |-> (slot_dist[g] <= slot_dist[g+1]));
        // R2: valid entries form an unbroken run from rank 0
        p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_vld[g] |-> !slot_vld[g+1]);
    end
endmodule

// File: rtl/rk_fsm.sv
module rk_fsm
    import rk_pkg::*;
#(
    parameter int K  = 15,
    parameter int CW = $clog2(K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          accept,
    output logic [CW-1:0] fill_cnt,
    output fill_state_e   state
);
    localparam logic [CW-1:0] K_CNT = CW'(K);

    fill_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = ST_EMPTY;
            cnt_d   = '0;
        end else if (accept) begin
            unique case (state_q)
                ST_EMPTY: begin
                    cnt_d   = cnt_q + 1'b1;
                    state_d = (cnt_d == K_CNT) ? ST_FULL : ST_FILLING;
                end
                ST_FILLING: begin
                    cnt_d   = cnt_q + 1'b1;
                    state_d = (cnt_d == K_CNT) ? ST_FULL : ST_FILLING;
                end
                ST_FULL: begin
                    cnt_d   = cnt_q;
                    state_d = ST_FULL;
                end
                default: begin
                    cnt_d   = '0;
                    state_d = ST_EMPTY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        fill_cnt = cnt_q;
        state    = state_q;
    end

    // R1: the empty state always reports a zero count
    p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (cnt_q == '0));
    // R7: the full state always reports K entries
    p_full_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> (cnt_q == K_CNT));
endmodule

// File: rtl/rank_keeper.sv
module rank_keeper
    import rk_pkg::*;
#(
    parameter int K      = 15,
    parameter int DIST_W = 32,
    parameter int ID_W   = 16,
    parameter int RW     = $clog2(K),
    parameter int CW     = $clog2(K + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cand_vld_i,
    input  logic [DIST_W-1:0] cand_dist_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [RW-1:0]     rd_rank_i,
    output logic              rd_hit_o,
    output logic [DIST_W-1:0] rd_dist_o,
    output logic [ID_W-1:0]   rd_id_o,
    output logic [CW-1:0]     fill_cnt_o
);
    localparam logic [CW-1:0] K_CNT  = CW'(K);
    localparam logic [RW:0]   K_RANK = (RW + 1)'(K);

    logic [K-1:0]             slot_vld;
    logic [K-1:0][DIST_W-1:0] slot_dist;
    logic [K-1:0][ID_W-1:0]   slot_id;
    logic [K-1:0]             beats;
    logic                     ins_any;
    logic                     ins_en;
    fill_state_e              state;

    assign ins_en = cand_vld_i && !clr_i;

    rk_compare #(.K(K), .DIST_W(DIST_W)) u_cmp (
        .slot_vld  (slot_vld),
        .slot_dist (slot_dist),
        .cand_dist (cand_dist_i),
        .beats     (beats),
        .ins_any   (ins_any)
    );

    rk_store #(.K(K), .DIST_W(DIST_W), .ID_W(ID_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_i),
        .ins_en    (ins_en),
        .beats     (beats),
        .cand_dist (cand_dist_i),
        .cand_id   (cand_id_i),
        .slot_vld  (slot_vld),
        .slot_dist (slot_dist),
        .slot_id   (slot_id)
    );

    rk_fsm #(.K(K), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_i),
        .accept   (ins_en && ins_any),
        .fill_cnt (fill_cnt_o),
        .state    (state)
    );

    // Registered read port; an index past the list returns an empty result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hit_o  <= 1'b0;
            rd_dist_o <= '0;
            rd_id_o   <= '0;
        end else if ({1'b0, rd_rank_i} < K_RANK) begin
            rd_hit_o  <= slot_vld[rd_rank_i];
            rd_dist_o <= slot_dist[rd_rank_i];
            rd_id_o   <= slot_id[rd_rank_i];
        end else begin
            rd_hit_o  <= 1'b0;
            rd_dist_o <= '0;
            rd_id_o   <= '0;
        end
    end

    // R1: a clear empties the list by the next edge
    p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (fill_cnt_o == '0));
    // R3: a candidate is never lost while the list has room
    p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_vld_i && !clr_i && fill_cnt_o != K_CNT)
            |=> (fill_cnt_o == $past(fill_cnt_o) + 1'b1));
    // R7: a full list stays full until cleared
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt_o == K_CNT && !clr_i) |=> (fill_cnt_o == K_CNT));
    // R5: a losing candidate on a full list changes nothing
    p_reject_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_vld_i && !clr_i && fill_cnt_o == K_CNT && cand_dist_i >= slot_dist[K-1])
            |=> ($stable(slot_dist) && $stable(slot_id)));
    // R9: an index past the list reads as a miss
    p_rd_oob_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_rank_i} >= K_RANK) |=> !rd_hit_o);
endmodule

// File: tb/rank_keeper_test.sv
`timescale 1ns/1ps
module rank_keeper_test;
    localparam int K = 15;
    localparam int NV = 20;
    // stimulus table: {distance, identifier}
    localparam logic [47:0] VEC [NV] = '{
        {32'd40, 16'd100}, {32'd12, 16'd101}, {32'd77, 16'd102}, {32'd12, 16'd103},
        {32'd5, 16'd104},  {32'd90, 16'd105}, {32'd33, 16'd106}, {32'd61, 16'd107},
        {32'd12, 16'd108}, {32'd8, 16'd109},  {32'd150, 16'd110}, {32'd5, 16'd111},
        {32'd44, 16'd112}, {32'd70, 16'd113}, {32'd99, 16'd114}, {32'd3, 16'd115},
        {32'd200, 16'd116}, {32'd61, 16'd117}, {32'd1, 16'd118}, {32'd88, 16'd119}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic cand_vld_i = 1'b0;
    logic [31:0] cand_dist_i = '0;
    logic [15:0] cand_id_i = '0;
    logic [3:0] rd_rank_i = '0;
    logic rd_hit_o;
    logic [31:0] rd_dist_o;
    logic [15:0] rd_id_o;
    logic [3:0] fill_cnt_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int unsigned mdist [K];
    int unsigned mid [K];
    int mcnt = 0;

    always #2 clk = ~clk;

    rank_keeper uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cand_vld_i(cand_vld_i),
        .cand_dist_i(cand_dist_i), .cand_id_i(cand_id_i), .rd_rank_i(rd_rank_i),
        .rd_hit_o(rd_hit_o), .rd_dist_o(rd_dist_o), .rd_id_o(rd_id_o),
        .fill_cnt_o(fill_cnt_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference insertion following R4 and R6
    task automatic model_add(input int unsigned d, input int unsigned id);
        int p = K;
        for (int i = K - 1; i >= 0; i--)
            if (i >= mcnt || d < mdist[i]) p = i;
        if (p < K) begin
            for (int i = K - 1; i > p; i--) begin
                mdist[i] = mdist[i-1];
                mid[i] = mid[i-1];
            end
            mdist[p] = d;
            mid[p] = id;
            if (mcnt < K) mcnt++;
        end
    endtask

    task automatic send(input int unsigned d, input int unsigned id);
        cand_vld_i = 1'b1;
        cand_dist_i = d;
        cand_id_i = id[15:0];
        @(negedge clk);
        cand_vld_i = 1'b0;
    endtask

    task automatic read_rank(input int r, output bit hit, output int unsigned d, output int unsigned id);
        rd_rank_i = r[3:0];
        @(negedge clk);
        hit = rd_hit_o;
        d = rd_dist_o;
        id = rd_id_o;
    endtask

    task automatic compare_all(input string req);
        bit h;
        int unsigned d, id;
        for (int r = 0; r < K; r++) begin
            read_rank(r, h, d, id);
            chk(h == (r < mcnt), {req, " hit"}, h, r < mcnt);
            if (r < mcnt) begin
                chk(d == mdist[r], {req, " dist"}, d, mdist[r]);
                chk(id == mid[r], {req, " id"}, id, mid[r]);
            end
        end
    endtask

    initial begin
        bit h;
        int unsigned d, id;
        int unsigned worst, worst_id;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(fill_cnt_o == 0, "R1 reset count", fill_cnt_o, 0);
        read_rank(0, h, d, id);
        chk(h == 0, "R1 reset rank0 miss", h, 0);

        // R3/R4/R6/R2: back-to-back stream from the table
        cand_vld_i = 1'b1;
        for (int v = 0; v < NV; v++) begin
            cand_dist_i = VEC[v][47:16];
            cand_id_i = VEC[v][15:0];
            model_add(VEC[v][47:16], VEC[v][15:0]);
            @(negedge clk);
        end
        cand_vld_i = 1'b0;
        chk(fill_cnt_o == K, "R7 saturated count", fill_cnt_o, K);
        compare_all("R2 R3 R4 R6 stream");

        // R5: candidate equal to the worst entry on a full list is dropped
        worst = mdist[K-1];
        worst_id = mid[K-1];
        send(worst, 16'h0ABC);
        read_rank(K - 1, h, d, id);
        chk(id == worst_id, "R5 equal-to-worst rejected id", id, worst_id);
        chk(fill_cnt_o == K, "R5 count held", fill_cnt_o, K);
        send(worst + 1000, 16'h0ABD);
        compare_all("R5 larger rejected");

        // R4: new best on a full list shifts everything, last falls off
        send(0, 16'h0777);
        model_add(0, 16'h0777);
        compare_all("R4 shift and drop");

        // R9: out-of-range rank returns an empty result
        read_rank(15, h, d, id);
        chk(h == 0, "R9 rank 15 miss", h, 0);
        chk(d == 0 && id == 0, "R9 rank 15 zero data", d + id, 0);

        // R8: clear wins over a candidate in the same cycle
        clr_i = 1'b1;
        cand_vld_i = 1'b1;
        cand_dist_i = 7;
        cand_id_i = 16'h0055;
        @(negedge clk);
        clr_i = 1'b0;
        cand_vld_i = 1'b0;
        mcnt = 0;
        chk(fill_cnt_o == 0, "R8 R1 clear count", fill_cnt_o, 0);
        read_rank(0, h, d, id);
        chk(h == 0, "R8 candidate discarded", h, 0);

        // R6 and R7: equal distances keep arrival order, count steps by one
        send(10, 16'h00A1);
        model_add(10, 16'h00A1);
        chk(fill_cnt_o == 1, "R7 count one", fill_cnt_o, 1);
        send(10, 16'h00A2);
        model_add(10, 16'h00A2);
        chk(fill_cnt_o == 2, "R7 count two", fill_cnt_o, 2);
        read_rank(0, h, d, id);
        chk(id == 16'h00A1, "R6 first arrival rank0", id, 16'h00A1);
        read_rank(1, h, d, id);
        chk(id == 16'h00A2, "R6 later arrival rank1", id, 16'h00A2);
        read_rank(2, h, d, id);
        chk(h == 0, "R2 rank2 empty", h, 0);

        // R9: read reflects the list before the same edge
        cand_vld_i = 1'b1;
        cand_dist_i = 2;
        cand_id_i = 16'h00B0;
        rd_rank_i = 4'd0;
        @(negedge clk);
        cand_vld_i = 1'b0;
        chk(rd_id_o == 16'h00A1, "R9 pre-edge read", rd_id_o, 16'h00A1);
        @(negedge clk);
        chk(rd_id_o == 16'h00B0, "R9 next read updated", rd_id_o, 16'h00B0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule